// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a selectable source clock into the timing enables a serial port needs. A 2-bit select chooses the source: the system clock, the system clock after a fixed prescaler, or rising edges of an external serial clock pin. In asynchronous mode the source is divided by a 16-bit integer divisor plus a 3-bit fraction in steps of one eighth. The result is a sampling enable. A baud enable is then derived from it by an oversampling factor of 16 or 8.

In synchronous mode the fraction and the oversampling factor are dropped. Every integer period yields one sampling enable and one baud enable together. When an internal source is selected, the block also drives a serial clock output. New settings are taken in only at the end of the period that is running, so a reconfiguration never shortens or splits an enable interval.

Top module: `fracBaudGen`

## Requirements
- R1: While reset is asserted, and after it until a nonzero divisor is applied, `sampleEn`, `baudEn` and `sckOut` are all low.
- R2: Source select 0 gives one source tick per system clock cycle, and select 1 gives one tick every `Prescale` (default 8) cycles. Select 3 gives one tick per synchronized rising edge of `sckIn`. Select 2 gives no ticks, so no enables are produced.
- R3: A divisor of 0 stops all enables and holds `sckOut` low. A divisor of 1 gives one `sampleEn` per source tick.
- R4: In asynchronous mode with fraction 0, `sampleEn` pulses every `divInt` source ticks. `baudEn` pulses on every 16th (`ovs8`=0) or every 8th (`ovs8`=1) `sampleEn`, and always in the same cycle as one.
- R5: In asynchronous mode with fraction F, each sampling period lasts `divInt` or `divInt`+1 ticks. Exactly F of any 8 consecutive periods are the longer kind, so one baud period lasts 16·`divInt`+2F ticks (16×) or 8·`divInt`+F ticks (8×).
- R6: In synchronous mode the fraction and oversampling are ignored: `sampleEn` and `baudEn` pulse together every `divInt` source ticks.
- R7: With select 3 the divisor and fraction have no effect, even when the divisor is 0. Every synchronized `sckIn` rising edge counts as one full sampling period.
- R8: In synchronous mode with select 0 or 1 and `divInt` ≥ 2, `sckOut` is high for ceil(`divInt`/2) source ticks of each period. With select 0 and an odd divisor it is instead high for exactly `divInt`/2 system clock periods, using a half-cycle step. `sckOut` stays low in asynchronous mode and with select 3.
- R9: A change to any setting takes effect at the next terminal count: the period in progress completes at its old length, and the next one uses the new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clkSel | input | 2 | Source select: 0 system, 1 prescaled, 2 none, 3 external pin |
| syncMode | input | 1 | 1 = synchronous mode, 0 = asynchronous mode |
| ovs8 | input | 1 | Asynchronous oversampling: 0 = 16×, 1 = 8× |
| divInt | input | 16 | Integer divisor |
| divFrac | input | 3 | Fraction in eighths (asynchronous mode only) |
| sckIn | input | 1 | External serial clock pin |
| sampleEn | output | 1 | One-cycle sampling clock enable |
| baudEn | output | 1 | One-cycle baud clock enable |
| sckOut | output | 1 | Serial clock output in synchronous master mode |

## Verification
A terminal source tick shows up as `sampleEn` one system clock after the edge that counted it. An external edge first passes two synchronizer flops and one edge-detect flop. `sckOut` follows the counter by one cycle, plus half a cycle on the odd-divisor path. The checks therefore never depend on absolute latency: they measure the cycles between consecutive enables at the falling clock edge, and the high time of `sckOut` in nanoseconds. Expected intervals are queued only after three enables have appeared under a new setting, because the first one loads the setting and the second closes the first clean period.

// File: rtl/fbgPkg.sv
`timescale 1ns/1ps
package fbgPkg;
  parameter int CdW = 16;
  parameter int FpW = 3;
  parameter int MaxOs = 16;

  typedef enum logic [1:0] {
    SrcSys  = 2'd0,
    SrcDiv  = 2'd1,
    SrcNone = 2'd2,
    SrcExt  = 2'd3
  } srcSelT;

  // settings held for one divide period
  typedef struct packed {
    logic [1:0]     sel;
    logic           syncMode;
    logic           over;
    logic [CdW-1:0] cd;
    logic [FpW-1:0] fp;
  } cfgT;

  // strobes from control to datapath
  typedef struct packed {
    logic srcTick;
    logic run;
    logic restart;
  } strbT;
endpackage

// File: rtl/fbgCtrl.sv
`timescale 1ns/1ps
module fbgCtrl
  import fbgPkg::*;
#(
  parameter int Prescale   = 8,
  parameter int SyncStages = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [1:0]     clkSel,
  input  logic           syncMode,
  input  logic           ovs8,
  input  logic [CdW-1:0] divInt,
  input  logic [FpW-1:0] divFrac,
  input  logic           sckIn,
  input  logic           atEnd,
  output cfgT            cfgQ,
  output strbT           strb
);
  localparam int PreW = (Prescale > 1) ? $clog2(Prescale) : 1;

  logic preTick;
  logic extTick;
  logic srcTick;
  logic idle;
  logic load;
  cfgT  rawCfg;

  // R2: fixed prescaler for the divided system clock
  generate
    if (Prescale > 1) begin : g_pre
      logic [PreW-1:0] preCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) preCnt <= '0;
        else if (preCnt == PreW'(Prescale - 1)) preCnt <= '0;
        else preCnt <= preCnt + PreW'(1);
      end
      assign preTick = (preCnt == PreW'(Prescale - 1));
    end else begin : g_nopre
      assign preTick = 1'b1;
    end
  endgenerate

  // R2/R7: external pin synchronizer and rising-edge detect
  logic [SyncStages:0] extQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extQ <= '0;
    else extQ <= {extQ[SyncStages-1:0], sckIn};
  end
  assign extTick = extQ[SyncStages-1] & ~extQ[SyncStages];

  // settings as they would apply; external source bypasses division
  always_comb begin
    rawCfg.sel      = clkSel;
    rawCfg.syncMode = syncMode;
    rawCfg.over     = ovs8;
    rawCfg.cd       = (clkSel == SrcExt) ? CdW'(1) : divInt;
    rawCfg.fp       = (syncMode || clkSel == SrcExt) ? '0 : divFrac;
  end

  always_comb begin
    case (cfgQ.sel)
      SrcSys:  srcTick = 1'b1;
      SrcDiv:  srcTick = preTick;
      SrcExt:  srcTick = extTick;
      default: srcTick = 1'b0;
    endcase
  end

  assign idle = (cfgQ.cd == '0) || (cfgQ.sel == SrcNone);
  // R9: reload only when stopped or at a terminal count
  assign load = idle || (srcTick && atEnd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else if (load) cfgQ <= rawCfg;
  end

  always_comb begin
    strb.srcTick = srcTick;
    strb.run     = !idle;
    strb.restart = load && (rawCfg != cfgQ);
  end
endmodule

// File: rtl/fbgDatapath.sv
`timescale 1ns/1ps
module fbgDatapath
  import fbgPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  cfgT  cfg,
  input  strbT strb,
  output logic atEnd,
  output logic sampleEn,
  output logic baudEn,
  output logic sckOut
);
  localparam int CntW = CdW + 1;
  localparam int OsW  = $clog2(MaxOs);

  logic [CntW-1:0] cnt;
  logic [CntW-1:0] periodLen;
  logic            stretch;
  logic [FpW-1:0]  acc;
  logic [FpW:0]    accSum;
  logic [OsW-1:0]  osCnt;
  logic [OsW-1:0]  osMax;
  logic            periodDone;
  logic [CdW-1:0]  ceilHalf;
  logic            sckMaster;
  logic            oddSys;
  logic            hiP;
  logic            hiN;

  // R5: a carry out of the accumulator lengthens the next period by one tick
  assign periodLen  = {1'b0, cfg.cd} + CntW'(stretch);
  assign atEnd      = ((cnt + CntW'(1)) == periodLen);
  assign accSum     = {1'b0, acc} + {1'b0, cfg.fp};
  assign osMax      = cfg.over ? OsW'(MaxOs / 2 - 1) : OsW'(MaxOs - 1);
  assign periodDone = strb.srcTick && atEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      acc      <= '0;
      stretch  <= 1'b0;
      osCnt    <= '0;
      sampleEn <= 1'b0;
      baudEn   <= 1'b0;
    end else if (!strb.run) begin
      // R3: stopped divider emits nothing
      cnt      <= '0;
      acc      <= '0;
      stretch  <= 1'b0;
      osCnt    <= '0;
      sampleEn <= 1'b0;
      baudEn   <= 1'b0;
    end else begin
      sampleEn <= periodDone;
      // R4/R6: baud on the last oversample, or every period when synchronous
      baudEn   <= periodDone && (cfg.syncMode || osCnt == osMax);
      if (strb.restart) begin
        cnt     <= '0;
        acc     <= '0;
        stretch <= 1'b0;
        osCnt   <= '0;
      end else if (strb.srcTick) begin
        if (atEnd) begin
          cnt     <= '0;
          acc     <= accSum[FpW-1:0];
          stretch <= accSum[FpW];
          osCnt   <= (osCnt == osMax) ? '0 : osCnt + OsW'(1);
        end else begin
          cnt <= cnt + CntW'(1);
        end
      end
    end
  end

  // R8: serial clock output
  assign ceilHalf  = (cfg.cd >> 1) + CdW'(cfg.cd[0]);
  assign sckMaster = strb.run && cfg.syncMode && (cfg.sel != SrcExt) && (cfg.cd >= CdW'(2));
  assign oddSys    = (cfg.sel == SrcSys) && cfg.cd[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hiP <= 1'b0;
    else hiP <= sckMaster && (cnt < {1'b0, ceilHalf});
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) hiN <= 1'b0;
    else hiN <= hiP;
  end

  // odd divisor on the system clock: trim half a cycle off the high phase
  assign sckOut = oddSys ? (hiP & hiN) : hiP;
endmodule

// File: rtl/fracBaudGen.sv
`timescale 1ns/1ps
module fracBaudGen
  import fbgPkg::*;
#(
  parameter int Prescale   = 8,
  parameter int SyncStages = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [1:0]     clkSel,
  input  logic           syncMode,
  input  logic           ovs8,
  input  logic [CdW-1:0] divInt,
  input  logic [FpW-1:0] divFrac,
  input  logic           sckIn,
  output logic           sampleEn,
  output logic           baudEn,
  output logic           sckOut
);
  cfgT  cfgQ;
  strbT strb;
  logic atEnd;

  fbgCtrl #(
    .Prescale  (Prescale),
    .SyncStages(SyncStages)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .clkSel  (clkSel),
    .syncMode(syncMode),
    .ovs8    (ovs8),
    .divInt  (divInt),
    .divFrac (divFrac),
    .sckIn   (sckIn),
    .atEnd   (atEnd),
    .cfgQ    (cfgQ),
    .strb    (strb)
  );

  fbgDatapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cfg     (cfgQ),
    .strb    (strb),
    .atEnd   (atEnd),
    .sampleEn(sampleEn),
    .baudEn  (baudEn),
    .sckOut  (sckOut)
  );
endmodule

// File: rtl/fracBaudGenChk.sv
`timescale 1ns/1ps
module fracBaudGenChk (
  input logic clk,
  input logic rstN,
  input logic sampleEn,
  input logic baudEn,
  input logic sckOut,
  input logic run,
  input logic cfgSync
);
  // R4: a baud enable always lands on a sampling enable
  a_r4_baud_on_sample: assert property (@(posedge clk) disable iff (!rstN)
    baudEn |-> sampleEn)
    else $error("baudEn without sampleEn");

  // R3: a stopped divider produces no sampling enable
  a_r3_idle_no_sample: assert property (@(posedge clk) disable iff (!rstN)
    $past(!run) |-> !sampleEn)
    else $error("sampleEn while stopped");

  // R3: a stopped divider holds the serial clock low
  a_r3_idle_no_sck: assert property (@(posedge clk) disable iff (!rstN)
    $past(!run) |-> !sckOut)
    else $error("sckOut high while stopped");

  // R8: no serial clock output in asynchronous mode
  a_r8_async_no_sck: assert property (@(posedge clk) disable iff (!rstN)
    $past(!cfgSync) |-> !sckOut)
    else $error("sckOut high in asynchronous mode");
endmodule

bind fracBaudGen fracBaudGenChk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .sampleEn(sampleEn),
  .baudEn  (baudEn),
  .sckOut  (sckOut),
  .run     (strb.run),
  .cfgSync (cfgQ.syncMode)
);

// File: tb/fracBaudGen_bench.sv
`timescale 1ns/1ps
module fracBaudGen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  clkSel = 2'd0;
  logic        syncMode = 1'b0;
  logic        ovs8 = 1'b0;
  logic [15:0] divInt = 16'd0;
  logic [2:0]  divFrac = 3'd0;
  logic        sckIn = 1'b0;
  logic        sampleEn, baudEn, sckOut;

  always #5 clk = ~clk;

  fracBaudGen u_fracBaudGen (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .syncMode(syncMode), .ovs8(ovs8),
    .divInt(divInt), .divFrac(divFrac), .sckIn(sckIn),
    .sampleEn(sampleEn), .baudEn(baudEn), .sckOut(sckOut)
  );

  typedef struct {
    int    lo;
    int    hi;
    string tag;
  } expT;

  expT sQ[$];
  expT bQ[$];
  expT hQ[$];
  expT eS, eB, eH;

  int  checks = 0, fails = 0;
  int  cyc = 0;
  int  sampleCnt = 0, baudCnt = 0, sckRise = 0;
  int  lastS = 0, lastB = 0;
  time riseT = 0;
  bit  done = 1'b0;
  bit  extOn = 1'b0;
  int  extPh = 0;

  always @(posedge clk) cyc++;

  task automatic checkRange(int act, expT e);
    checks++;
    if (act < e.lo || act > e.hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", e.tag, act, e.lo, e.hi);
    end
  endtask

  task automatic checkEq(int act, int expv, string tag);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // monitor: pops expectations as enables and clock phases appear
  always @(negedge clk) begin
    if (sampleEn) begin
      if (sQ.size() > 0) begin
        eS = sQ.pop_front();
        checkRange(cyc - lastS, eS);
      end
      lastS = cyc;
      sampleCnt++;
    end
    if (baudEn) begin
      if (bQ.size() > 0) begin
        eB = bQ.pop_front();
        checkRange(cyc - lastB, eB);
      end
      lastB = cyc;
      baudCnt++;
    end
  end

  always @(posedge sckOut) begin
    riseT = $time;
    sckRise++;
  end

  always @(negedge sckOut) begin
    if (hQ.size() > 0) begin
      eH = hQ.pop_front();
      checkRange(int'($time - riseT), eH);
    end
  end

  // external clock: 3 cycles high, 3 low
  always @(negedge clk) begin
    if (extOn) begin
      extPh = (extPh + 1) % 6;
      sckIn <= (extPh < 3);
    end else begin
      sckIn <= 1'b0;
    end
  end

  task automatic pushS(int lo, int hi, int n, string tag);
    repeat (n) sQ.push_back('{lo, hi, tag});
  endtask
  task automatic pushB(int lo, int hi, int n, string tag);
    repeat (n) bQ.push_back('{lo, hi, tag});
  endtask
  task automatic pushH(int lo, int hi, int n, string tag);
    repeat (n) hQ.push_back('{lo, hi, tag});
  endtask

  task automatic waitS(int n);
    int target = sampleCnt + n;
    wait (sampleCnt >= target);
  endtask
  task automatic waitB(int n);
    int target = baudCnt + n;
    wait (baudCnt >= target);
  endtask
  task automatic drain();
    wait (sQ.size() == 0 && bQ.size() == 0 && hQ.size() == 0);
  endtask

  task automatic setCfg(logic [1:0] s, logic sy, logic o8, logic [15:0] ci, logic [2:0] cf);
    @(negedge clk);
    clkSel = s; syncMode = sy; ovs8 = o8; divInt = ci; divFrac = cf;
  endtask

  initial begin
    int snap;
    int snapR;
    repeat (4) @(negedge clk);
    checkEq(int'(sampleEn), 0, "R1 sampleEn in reset");
    checkEq(int'(baudEn), 0, "R1 baudEn in reset");
    checkEq(int'(sckOut), 0, "R1 sckOut in reset");
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    checkEq(sampleCnt, 0, "R1 R3 no enables with divisor 0");
    checkEq(int'(sckOut), 0, "R1 sckOut low after reset");

    // divisor 1, 8x oversampling
    setCfg(2'd0, 1'b0, 1'b1, 16'd1, 3'd0);
    waitS(3); pushS(1, 1, 4, "R3 divisor 1");
    waitB(1); pushB(8, 8, 2, "R4 8x baud");
    drain();

    // integer divide, 16x
    setCfg(2'd0, 1'b0, 1'b0, 16'd5, 3'd0);
    waitS(3); pushS(5, 5, 4, "R4 integer period");
    waitB(1); pushB(80, 80, 2, "R4 16x baud");
    drain();

    // fraction 3/8, 8x
    setCfg(2'd0, 1'b0, 1'b1, 16'd4, 3'd3);
    waitS(3); pushS(4, 5, 8, "R5 period cd or cd+1");
    waitB(1); pushB(35, 35, 3, "R5 8x fractional baud");
    drain();

    // fraction 5/8, 16x
    setCfg(2'd0, 1'b0, 1'b0, 16'd3, 3'd5);
    waitS(3); waitB(1);
    pushB(58, 58, 2, "R5 16x fractional baud");
    pushS(3, 4, 6, "R5 period cd or cd+1");
    drain();
    checkEq(sckRise, 0, "R8 no sckOut in asynchronous mode");

    // prescaled source
    setCfg(2'd1, 1'b0, 1'b1, 16'd2, 3'd0);
    waitS(3); pushS(16, 16, 3, "R2 prescaled period");
    waitB(1); pushB(128, 128, 2, "R2 prescaled baud");
    drain();

    // synchronous, system clock, odd divisor, fraction ignored
    setCfg(2'd0, 1'b1, 1'b0, 16'd5, 3'd7);
    waitS(3);
    pushS(5, 5, 4, "R6 sync period ignores fraction");
    pushB(5, 5, 3, "R6 sync baud every period");
    pushH(25, 25, 3, "R8 odd divisor 50% high time");
    drain();

    // synchronous, system clock, even divisor
    setCfg(2'd0, 1'b1, 1'b0, 16'd4, 3'd0);
    waitS(3); pushH(20, 20, 3, "R8 even divisor high time");
    drain();

    // synchronous, prescaled, odd divisor
    setCfg(2'd1, 1'b1, 1'b0, 16'd3, 3'd0);
    waitS(3);
    pushS(24, 24, 3, "R6 sync prescaled period");
    pushH(160, 160, 2, "R8 prescaled ceil high time");
    drain();

    // reload at terminal count
    setCfg(2'd0, 1'b0, 1'b1, 16'd6, 3'd0);
    waitS(3); waitS(1);
    repeat (2) @(negedge clk);
    divInt = 16'd3;
    pushS(6, 6, 1, "R9 running period keeps old length");
    pushS(3, 3, 2, "R9 new length after terminal count");
    drain();

    // external clock, synchronous, divisor 0 and fraction set
    extOn = 1'b1;
    setCfg(2'd3, 1'b1, 1'b0, 16'd0, 3'd5);
    waitS(3);
    snapR = sckRise;
    pushS(6, 6, 4, "R7 external edge per period");
    pushB(6, 6, 2, "R7 external sync baud");
    drain();
    checkEq(sckRise - snapR, 0, "R8 no sckOut with external source");

    // external clock, asynchronous 8x
    setCfg(2'd3, 1'b0, 1'b1, 16'd0, 3'd0);
    waitS(3); waitB(1);
    pushB(48, 48, 2, "R7 external async baud");
    drain();

    // reserved select stops everything
    setCfg(2'd2, 1'b0, 1'b0, 16'd5, 3'd0);
    waitS(1);
    repeat (3) @(negedge clk);
    snap = sampleCnt;
    repeat (100) @(negedge clk);
    checkEq(sampleCnt - snap, 0, "R2 select 2 gives no enables");
    extOn = 1'b0;

    // divisor 0 stops a running synchronous clock
    setCfg(2'd0, 1'b1, 1'b0, 16'd4, 3'd0);
    waitS(3);
    setCfg(2'd0, 1'b1, 1'b0, 16'd0, 3'd0);
    waitS(1);
    repeat (3) @(negedge clk);
    snap = sampleCnt;
    snapR = sckRise;
    repeat (60) @(negedge clk);
    checkEq(sampleCnt - snap, 0, "R3 divisor 0 stops enables");
    checkEq(sckRise - snapR, 0, "R3 divisor 0 stops sckOut");
    checkEq(int'(sckOut), 0, "R3 sckOut held low");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule